// File: doc/BRIEF.md
# Sprite Overlay Pixel Pipeline

This block lays four movable 32x32 sprite images over a background pixel stream for a 640x480, 60 Hz display. For every pixel it receives the raster coordinates and a 4-bit background colour index. It tests each sprite for a hit, maps the screen offset back into image coordinates (mirror and quarter-turn rotation), reads the sprite image and keeps the highest-priority opaque sprite. The chosen 4-bit index then goes through a 16-entry palette to give a 6-bit RGB output. The path is a fixed four-stage pipeline.

A CPU programs sprites and palette through an 8-bit register write port. Writes land in shadow registers. All shadow contents are copied into the live set on a one-cycle `frame_start` pulse, given during vertical blank, so a sprite never tears halfway down the screen. The sprite images are fixed and computed inside the block, so no memory needs to be loaded.

The pixel input carries a valid flag but has no ready signal. Video cannot be stalled, so there is no back-pressure: the pipeline advances every clock, and a pixel presented with `px_valid` high comes out four clocks later whatever happens downstream.

Top module: `sprite_overlay_engine`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` and `out_rgb` are 0. Every sprite is disabled and every palette entry is 0 until it is programmed and a frame pulse is given.
- R2: Sprite s covers pixel (x,y) when it is enabled and both dx=(x-X) mod 1024 and dy=(y-Y) mod 1024 are below 32. A sprite placed near 1023 therefore wraps onto the left or top edge.
- R3: `out_valid` equals `px_valid` from exactly four clocks earlier. `out_rgb` is 0 whenever `out_valid` is 0. There is no back-pressure.
- R4: Image k (0..3) has colour c(u,v) = (u[4:3] + k*v[4:3]) mod 4 at column u and row v. Colour 0 is transparent.
- R5: Where several sprites are opaque, the lowest-numbered sprite wins. Sprite s with colour c selects palette entry 4*s+c.
- R6: A pixel where no sprite is opaque selects palette entry `px_bg`.
- R7: With rotation r, the source point (a,b) is (dx,dy) for r=0, (dy,31-dx) for r=1, (31-dx,31-dy) for r=2 and (31-dy,dx) for r=3. Then u = 31-a if mirror is set, otherwise u = a, and v = b.
- R8: A register write changes nothing visible until the next `frame_start`. A write made in the same cycle as `frame_start` waits for the following pulse.
- R9: Register map. Address 8*s+0 holds X[7:0]. Address 8*s+1 holds X[9:8] in bits 1:0. Address 8*s+2 holds Y[7:0]. Address 8*s+3 holds Y[9:8] in bits 1:0. Address 8*s+4 is the control register: bit0 enable, bits 2:1 rotation, bit3 mirror, bits 5:4 image. Palette entry i (0..15) sits at address 32+i, bits 5:0. Writes to sprite offsets 5..7 and to addresses 48..63 have no effect.
- R10: `out_rgb` is the 6-bit contents of the selected palette entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | synchronous active-low reset |
| frame_start | input | 1 | one-cycle pulse in vertical blank; copies shadow registers into the live set |
| cfg_we | input | 1 | register write strobe |
| cfg_addr | input | 6 | register address |
| cfg_wdata | input | 8 | register write data |
| px_valid | input | 1 | input pixel is active video |
| px_x | input | 10 | pixel column |
| px_y | input | 10 | pixel row |
| px_bg | input | 4 | background palette index |
| out_valid | output | 1 | output pixel is active video |
| out_rgb | output | 6 | output colour |

## Verification
The assertions check four things on every cycle. They check the four-clock valid latency and black output outside active video. They check that the live register set moves only on a frame pulse. They also check that the last stage picks the background entry when every sprite lane is transparent, and sprite 0's entry when that lane is opaque. The scenarios are the only way to show that sprite images are correct. They cover all eight rotation and mirror combinations, the edge and wrap-around hit windows, priority between overlapping sprites, the deferred write at a frame pulse and the ignored addresses. In each case the bench compares every output pixel against its own model.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  localparam int NUM_SPR   = 4;
  localparam int SPR_LG    = 5;
  localparam int COORD_W   = 10;
  localparam int COL_W     = 2;
  localparam int IMG_W     = 2;
  localparam int ROT_W     = 2;
  localparam int RGB_W     = 6;
  localparam int SPR_IDX_W = $clog2(NUM_SPR);
  localparam int PAL_IDX_W = SPR_IDX_W + COL_W;
  localparam int PAL_N     = 1 << PAL_IDX_W;
  localparam int CFG_AW    = 6;
  localparam int CFG_DW    = 8;
  localparam int PIPE_LAT  = 4;

  typedef struct packed {
    logic [COORD_W-1:0] x;
    logic [COORD_W-1:0] y;
    logic [IMG_W-1:0]   img;
    logic               mir;
    logic [ROT_W-1:0]   rot;
    logic               en;
  } spr_cfg_t;

  // Fixed sprite artwork: banded patterns computed from the coordinates.
  function automatic logic [COL_W-1:0] img_pixel(input logic [IMG_W-1:0] img,
                                                 input logic [SPR_LG-1:0] u,
                                                 input logic [SPR_LG-1:0] v);
    logic [COL_W-1:0]   ub;
    logic [COL_W-1:0]   vb;
    logic [2*COL_W-1:0] prod;
    ub   = u[SPR_LG-1 -: COL_W];
    vb   = v[SPR_LG-1 -: COL_W];
    prod = {{(2*COL_W-IMG_W){1'b0}}, img} * {{COL_W{1'b0}}, vb};
    return ub + prod[COL_W-1:0];
  endfunction
endpackage

// File: rtl/ovl_cfg_bank.sv
`timescale 1ns/1ps
module ovl_cfg_bank
  import ovl_pkg::*;
(
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                frame_start,
  input  logic                                cfg_we,
  input  logic [CFG_AW-1:0]                   cfg_addr,
  input  logic [CFG_DW-1:0]                   cfg_wdata,
  output spr_cfg_t [NUM_SPR-1:0]              spr_act,
  output logic [PAL_N-1:0][RGB_W-1:0]         pal_act
);
  localparam int HI_W = COORD_W - CFG_DW;

  spr_cfg_t [NUM_SPR-1:0]      spr_sh;
  logic [PAL_N-1:0][RGB_W-1:0] pal_sh;

  logic                 sel_spr;
  logic                 sel_pal;
  logic [SPR_IDX_W-1:0] spr_sel;

  always_comb begin
    sel_spr = cfg_we && !cfg_addr[CFG_AW-1];
    sel_pal = cfg_we && (cfg_addr[CFG_AW-1 -: 2] == 2'b10);
    spr_sel = cfg_addr[3 +: SPR_IDX_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      spr_sh  <= '0;
      pal_sh  <= '0;
      spr_act <= '0;
      pal_act <= '0;
    end else begin
      // The live set takes the shadow contents from before any same-cycle write.
      if (frame_start) begin
        spr_act <= spr_sh;
        pal_act <= pal_sh;
      end
      if (sel_spr) begin
        case (cfg_addr[2:0])
          3'd0: spr_sh[spr_sel].x[CFG_DW-1:0]       <= cfg_wdata;
          3'd1: spr_sh[spr_sel].x[COORD_W-1:CFG_DW] <= cfg_wdata[HI_W-1:0];
          3'd2: spr_sh[spr_sel].y[CFG_DW-1:0]       <= cfg_wdata;
          3'd3: spr_sh[spr_sel].y[COORD_W-1:CFG_DW] <= cfg_wdata[HI_W-1:0];
          3'd4: begin
            spr_sh[spr_sel].en  <= cfg_wdata[0];
            spr_sh[spr_sel].rot <= cfg_wdata[2:1];
            spr_sh[spr_sel].mir <= cfg_wdata[3];
            spr_sh[spr_sel].img <= cfg_wdata[5:4];
          end
          default: ;
        endcase
      end
      if (sel_pal) pal_sh[cfg_addr[PAL_IDX_W-1:0]] <= cfg_wdata[RGB_W-1:0];
    end
  end
endmodule

// File: rtl/ovl_sprite_lane.sv
`timescale 1ns/1ps
module ovl_sprite_lane
  import ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] px_x,
  input  logic [COORD_W-1:0] px_y,
  input  spr_cfg_t           cfg,
  output logic [COL_W-1:0]   col_o
);
  // stage 1: offset and hit window
  logic [COORD_W-1:0] dx;
  logic [COORD_W-1:0] dy;
  logic               hit1;
  logic [SPR_LG-1:0]  dx1;
  logic [SPR_LG-1:0]  dy1;
  logic [ROT_W-1:0]   rot1;
  logic               mir1;
  logic [IMG_W-1:0]   img1;

  always_comb begin
    dx = px_x - cfg.x;
    dy = px_y - cfg.y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit1 <= 1'b0;
      dx1  <= '0;
      dy1  <= '0;
      rot1 <= '0;
      mir1 <= 1'b0;
      img1 <= '0;
    end else begin
      hit1 <= cfg.en && (dx[COORD_W-1:SPR_LG] == '0) && (dy[COORD_W-1:SPR_LG] == '0);
      dx1  <= dx[SPR_LG-1:0];
      dy1  <= dy[SPR_LG-1:0];
      rot1 <= cfg.rot;
      mir1 <= cfg.mir;
      img1 <= cfg.img;
    end
  end

  // stage 2: inverse rotation, then inverse mirror
  logic [SPR_LG-1:0] ra;
  logic [SPR_LG-1:0] rb;
  logic [SPR_LG-1:0] u2;
  logic [SPR_LG-1:0] v2;
  logic              hit2;
  logic [IMG_W-1:0]  img2;

  always_comb begin
    case (rot1)
      2'd0:    begin ra = dx1;  rb = dy1;  end
      2'd1:    begin ra = dy1;  rb = ~dx1; end
      2'd2:    begin ra = ~dx1; rb = ~dy1; end
      default: begin ra = ~dy1; rb = dx1;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u2   <= '0;
      v2   <= '0;
      hit2 <= 1'b0;
      img2 <= '0;
    end else begin
      u2   <= mir1 ? ~ra : ra;
      v2   <= rb;
      hit2 <= hit1;
      img2 <= img1;
    end
  end

  // stage 3: image fetch
  always_ff @(posedge clk) begin
    if (!rst_n) col_o <= '0;
    else        col_o <= hit2 ? img_pixel(img2, u2, v2) : '0;
  end
endmodule

// File: rtl/ovl_merge_out.sv
`timescale 1ns/1ps
module ovl_merge_out
  import ovl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         v_i,
  input  logic [NUM_SPR-1:0][COL_W-1:0] col_i,
  input  logic [PAL_IDX_W-1:0]         bg_i,
  input  logic [PAL_N-1:0][RGB_W-1:0]  pal,
  output logic                         out_valid,
  output logic [RGB_W-1:0]             out_rgb
);
  logic [PAL_IDX_W-1:0] idx;

  always_comb begin
    idx = bg_i;
    // descending walk so the lowest-numbered opaque lane is written last
    for (int s = NUM_SPR - 1; s >= 0; s--) begin
      if (col_i[s] != '0) idx = PAL_IDX_W'((s << COL_W) | int'(col_i[s]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_rgb   <= '0;
    end else begin
      out_valid <= v_i;
      out_rgb   <= v_i ? pal[idx] : '0;
    end
  end
endmodule

// File: rtl/sprite_overlay_engine.sv
`timescale 1ns/1ps
module sprite_overlay_engine
  import ovl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  input  logic                 px_valid,
  input  logic [COORD_W-1:0]   px_x,
  input  logic [COORD_W-1:0]   px_y,
  input  logic [PAL_IDX_W-1:0] px_bg,
  output logic                 out_valid,
  output logic [RGB_W-1:0]     out_rgb
);
  localparam int SIDE_DEPTH = PIPE_LAT - 1;

  spr_cfg_t [NUM_SPR-1:0]               spr_act;
  logic [PAL_N-1:0][RGB_W-1:0]          pal_act;
  logic [NUM_SPR-1:0][COL_W-1:0]        lane_col;
  logic [SIDE_DEPTH-1:0]                v_pipe;
  logic [SIDE_DEPTH-1:0][PAL_IDX_W-1:0] bg_pipe;
  logic                                 v3;
  logic [PAL_IDX_W-1:0]                 bg3;

  ovl_cfg_bank i_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .spr_act(spr_act), .pal_act(pal_act)
  );

  for (genvar s = 0; s < NUM_SPR; s++) begin : g_lane
    ovl_sprite_lane i_lane (
      .clk(clk), .rst_n(rst_n), .px_x(px_x), .px_y(px_y),
      .cfg(spr_act[s]), .col_o(lane_col[s])
    );
  end

  // valid and background travel beside the lanes for three stages
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_pipe  <= '0;
      bg_pipe <= '0;
    end else begin
      v_pipe  <= {v_pipe[SIDE_DEPTH-2:0], px_valid};
      bg_pipe <= {bg_pipe[SIDE_DEPTH-2:0], px_bg};
    end
  end

  assign v3  = v_pipe[SIDE_DEPTH-1];
  assign bg3 = bg_pipe[SIDE_DEPTH-1];

  ovl_merge_out i_out (
    .clk(clk), .rst_n(rst_n), .v_i(v3), .col_i(lane_col), .bg_i(bg3),
    .pal(pal_act), .out_valid(out_valid), .out_rgb(out_rgb)
  );
endmodule

// File: rtl/ovl_checker.sv
`timescale 1ns/1ps
module ovl_checker
  import ovl_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          frame_start,
  input logic                          px_valid,
  input logic                          out_valid,
  input logic [RGB_W-1:0]              out_rgb,
  input logic                          v3,
  input logic [PAL_IDX_W-1:0]          bg3,
  input logic [NUM_SPR-1:0][COL_W-1:0] col3,
  input spr_cfg_t [NUM_SPR-1:0]        spr_act,
  input logic [PAL_N-1:0][RGB_W-1:0]   pal_act
);
  logic [2:0] since_rst;
  logic       warm;

  always_ff @(posedge clk) begin
    if (!rst_n)                         since_rst <= '0;
    else if (since_rst != 3'(PIPE_LAT)) since_rst <= since_rst + 3'd1;
  end
  assign warm = (since_rst == 3'(PIPE_LAT));

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (out_valid == $past(px_valid, 4)));

  p_black_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_rgb == '0));

  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(spr_act) && $stable(pal_act)));

  p_bg_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (v3 && col3 == '0) |=> (out_rgb == $past(pal_act[bg3])));

  p_top_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (v3 && col3[0] != '0) |=> (out_rgb == $past(pal_act[PAL_IDX_W'(col3[0])])));
endmodule

bind sprite_overlay_engine ovl_checker i_ovl_checker (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .px_valid(px_valid),
  .out_valid(out_valid), .out_rgb(out_rgb), .v3(v3), .bg3(bg3),
  .col3(lane_col), .spr_act(spr_act), .pal_act(pal_act)
);

// File: tb/test_sprite_overlay_engine.sv
`timescale 1ns/1ps
module test_sprite_overlay_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       px_valid = 1'b0;
  logic [9:0] px_x = '0;
  logic [9:0] px_y = '0;
  logic [3:0] px_bg = '0;
  logic       out_valid;
  logic [5:0] out_rgb;

  always #2 clk = ~clk;

  sprite_overlay_engine i_sprite_overlay_engine (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  int sh[64];
  int ac[64];
  int ev[4200];

  task automatic check(bit ok, string tag, int got, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // reference model built from the requirement text; result = valid*64 + rgb
  function automatic int model(int x, int y, int bg);
    for (int s = 0; s < 4; s++) begin
      int b = s * 8;
      int sx = ((sh_dummy(ac[b+1]) & 3) << 8) | ac[b];
      int sy = ((ac[b+3] & 3) << 8) | ac[b+2];
      int ct = ac[b+4];
      int dx = (x - sx) & 1023;
      int dy = (y - sy) & 1023;
      int a, bb, u, col;
      if ((ct & 1) != 0 && dx < 32 && dy < 32) begin
        case ((ct >> 1) & 3)
          0: begin a = dx;      bb = dy;      end
          1: begin a = dy;      bb = 31 - dx; end
          2: begin a = 31 - dx; bb = 31 - dy; end
          default: begin a = 31 - dy; bb = dx; end
        endcase
        u = ((ct & 8) != 0) ? 31 - a : a;
        col = ((u >> 3) + ((ct >> 4) & 3) * (bb >> 3)) % 4;
        if (col != 0) return 64 + (ac[32 + s*4 + col] & 63);
      end
    end
    return 64 + (ac[32 + bg] & 63);
  endfunction

  function automatic int sh_dummy(int v);
    return v;
  endfunction

  task automatic wr(int addr, int data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 6'(addr); cfg_wdata = 8'(data);
    sh[addr] = data & 255;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    for (int i = 0; i < 64; i++) ac[i] = sh[i];
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic set_spr(int s, int x, int y, int en, int rot, int mir, int img);
    wr(s*8 + 0, x & 255);
    wr(s*8 + 1, (x >> 8) & 3);
    wr(s*8 + 2, y & 255);
    wr(s*8 + 3, (y >> 8) & 3);
    wr(s*8 + 4, en | (rot << 1) | (mir << 3) | (img << 4));
  endtask

  // streams a w x h window; output of slot i is sampled four negedges later
  task automatic run(int x0, int y0, int w, int h, bit gap, string tag);
    int n = w * h;
    for (int i = 0; i < n + 4; i++) begin
      @(negedge clk);
      if (i >= 4) begin
        int got = (out_valid ? 64 : 0) + int'(out_rgb);
        check(got == ev[i-4], tag, got, ev[i-4]);
      end
      if (i < n) begin
        int x = (x0 + i % w) & 1023;
        int y = (y0 + i / w) & 1023;
        int bg = (x + 3*y) % 16;
        bit v = !(gap && (i % 3 == 2));
        px_valid = v; px_x = 10'(x); px_y = 10'(y); px_bg = 4'(bg);
        ev[i] = v ? model(x, y, bg) : 0;
      end else begin
        px_valid = 1'b0;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    px_valid = 1'b1;
    repeat (5) @(negedge clk);
    check(out_valid == 1'b0 && out_rgb == '0, "R1 in reset", int'(out_rgb), 0);
    rst_n = 1'b1;
    px_valid = 1'b0;
    for (int i = 0; i < 64; i++) begin sh[i] = 0; ac[i] = 0; end
    @(negedge clk);
    check(out_valid == 1'b0 && out_rgb == '0, "R1 after release", int'(out_rgb), 0);
    run(0, 0, 20, 4, 1'b0, "R1 unprogrammed black");
  endtask

  task automatic t_background();
    for (int i = 0; i < 16; i++) wr(32 + i, (i*5 + 3) & 63);
    frame();
    run(300, 200, 24, 8, 1'b0, "R6 R10 background");
  endtask

  task automatic t_shadow();
    set_spr(0, 100, 60, 1, 0, 0, 2);
    run(96, 58, 40, 6, 1'b0, "R8 shadow not live");
    frame();
    run(96, 58, 40, 36, 1'b0, "R4 image after frame");
  endtask

  task automatic t_transform();
    for (int r = 0; r < 4; r++) begin
      for (int m = 0; m < 2; m++) begin
        wr(4, 1 | (r << 1) | (m << 3) | (2 << 4));
        frame();
        run(99, 59, 34, 34, 1'b0, "R7 rotate mirror");
      end
    end
  endtask

  task automatic t_priority();
    set_spr(0, 200, 100, 1, 0, 0, 0);
    set_spr(1, 210, 110, 1, 0, 0, 1);
    frame();
    run(195, 95, 50, 50, 1'b0, "R5 priority");
  endtask

  task automatic t_window();
    set_spr(2, 1020, 1020, 1, 0, 0, 3);
    set_spr(3, 608, 448, 1, 1, 1, 1);
    frame();
    run(0, 0, 36, 36, 1'b1, "R2 R3 wrap with gaps");
    run(1010, 1010, 14, 14, 1'b0, "R2 wrap top left");
    run(600, 440, 40, 40, 1'b1, "R2 R3 screen edge");
  endtask

  task automatic t_unmapped();
    for (int a = 48; a < 64; a++) wr(a, 255);
    for (int s = 0; s < 4; s++) for (int k = 5; k < 8; k++) wr(s*8 + k, 255);
    frame();
    run(195, 95, 50, 20, 1'b0, "R9 unmapped ignored");
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    frame_start = 1'b1; cfg_we = 1'b1; cfg_addr = 6'd37; cfg_wdata = 8'd60;
    for (int i = 0; i < 64; i++) ac[i] = sh[i];
    sh[37] = 60;
    @(negedge clk);
    frame_start = 1'b0; cfg_we = 1'b0;
    run(300, 200, 16, 4, 1'b0, "R8 same cycle write deferred");
    frame();
    run(300, 200, 16, 4, 1'b0, "R8 deferred write now live");
  endtask

  task automatic finish_up();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_background();
    t_shadow();
    t_transform();
    t_priority();
    t_window();
    t_unmapped();
    t_same_cycle();
    finish_up();
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1");
      finish_up();
    end
  end
endmodule